// File: doc/BRIEF.md
# Fractional-N Divide Ratio Modulator

This block produces the division ratio that a fractional-N PLL feedback divider should use for each comparison period. It takes a 15-bit integer part, a 20-bit fractional word and a mode bit. In integer mode it presents the integer part unchanged. In fractional mode it adds a small offset from a second-order cascaded delta-sigma modulator to the integer part. Over a long run, the average ratio is the integer part plus the fractional word divided by 2^20.

A reference divider shares the block. It turns a fast reference clock into a one-cycle comparison enable every N clock cycles, where N is programmable from 1 to 1023. The modulator advances only on that enable. The block checks the integer part against a legal window and flags illegal values. The upper limit of that window is lower in fractional mode, so that the divider plus its dither stays inside the range the counter supports. An illegal integer part is clamped to the nearest legal value before it is used.

Top module: `fracn_ratio_mod`

## Requirements
- R1: A synchronous reset (srst high at a rising edge) sets div_val to 0, cmp_en to 0 and range_err to 0, and clears the modulator state.
- R2: With reference divisor N on ref_div_val (1 to 1023, with 0 treated as 1), cmp_en is a one-cycle pulse that repeats every N clock cycles. When N is 1, cmp_en stays high.
- R3: div_val changes only on the clock edge after a cycle in which cmp_en is high, and holds its value at every other edge.
- R4: In integer mode (frac_mode = 0) with a legal integer part, each update makes div_val equal to int_part. The fractional word has no effect.
- R5: In fractional mode (frac_mode = 1), each update gives a div_val in the range from the effective integer part minus 1 to the effective integer part plus 2.
- R6: Integer mode clears the modulator state. After fractional mode is entered from integer mode or from reset, the sum of the first K div_val updates is K·I + floor(K·F/2^20) or one more than that. I is the effective integer part and F is frac_word. For K = 2^16, the mean is within 2^-12 of I + F/2^20.
- R7: In fractional mode an integer part above 251 is illegal. range_err goes to 1 one cycle later, and 251 is used as the integer part.
- R8: An integer part below 36 is illegal in either mode. range_err goes to 1 one cycle later, and 36 is used. A legal setting gives range_err = 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| srst | input | 1 | Synchronous reset, active high |
| ref_div_val | input | 10 | Reference divisor N (0 acts as 1) |
| int_part | input | 15 | Integer part of the feedback ratio |
| frac_word | input | 20 | Fractional word; the fraction is frac_word/2^20 |
| frac_mode | input | 1 | 1 selects fractional mode, 0 selects integer mode |
| cmp_en | output | 1 | Comparison-clock enable pulse |
| div_val | output | 16 | Divide value for the current comparison period |
| range_err | output | 1 | Registered flag for an illegal integer part |

## Verification
The properties assume that the reference divisor and the integer part stay constant across the cycles each property observes. For example, the pulse-spacing property only applies while ref_div_val is stable, and the per-update bounds compare against the integer part sampled at the enable. The stimulus changes inputs only at falling edges at vector boundaries, and each fractional vector is preceded by several cycles in integer mode. This means every sum check starts from a cleared modulator, so the exact floor-plus-one bound applies.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
    localparam int FRACN_INT_W   = 15;
    localparam int FRACN_FRAC_W  = 20;
    localparam int FRACN_RDIV_W  = 10;
    localparam int FRACN_INT_MIN = 36;
    localparam int FRACN_FRAC_INT_MAX = 251;

    // Offset from the cascaded modulator, range -1 .. +2, two's complement
    typedef logic [2:0] mash_ofs_t;
endpackage

// File: rtl/fracn_ref_div.sv
module fracn_ref_div #(
    parameter int RDIV_W = fracn_pkg::FRACN_RDIV_W
) (
    input  logic              clk,
    input  logic              srst,
    input  logic [RDIV_W-1:0] divisor,
    output logic              cmp_en
);
    typedef struct packed {
        logic [RDIV_W-1:0] cnt;
        logic              en;
    } rdiv_st_t;

    rdiv_st_t st_d, st_q;
    logic [RDIV_W-1:0] limit;

    always_comb begin
        limit = (divisor == '0) ? '0 : divisor - RDIV_W'(1);
        st_d  = st_q;
        if (st_q.cnt >= limit) begin
            st_d.cnt = '0;
            st_d.en  = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + RDIV_W'(1);
            st_d.en  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (srst) st_q <= '0;
        else      st_q <= st_d;
    end

    assign cmp_en = st_q.en;
endmodule

// File: rtl/fracn_int_guard.sv
module fracn_int_guard #(
    parameter int INT_W   = fracn_pkg::FRACN_INT_W,
    parameter int INT_MIN = fracn_pkg::FRACN_INT_MIN,
    parameter int FRAC_MAX = fracn_pkg::FRACN_FRAC_INT_MAX
) (
    input  logic [INT_W-1:0] int_part,
    input  logic             frac_mode,
    output logic [INT_W-1:0] int_eff,
    output logic             illegal
);
    localparam logic [INT_W-1:0] MIN_V = INT_W'(INT_MIN);
    localparam logic [INT_W-1:0] MAX_V = INT_W'(FRAC_MAX);

    always_comb begin
        int_eff = int_part;
        illegal = 1'b0;
        if (int_part < MIN_V) begin
            int_eff = MIN_V;
            illegal = 1'b1;
        end else if (frac_mode && (int_part > MAX_V)) begin
            int_eff = MAX_V;
            illegal = 1'b1;
        end
    end
endmodule

// File: rtl/fracn_mash11.sv
module fracn_mash11 #(
    parameter int FRAC_W = fracn_pkg::FRACN_FRAC_W
) (
    input  logic              clk,
    input  logic              srst,
    input  logic              active,
    input  logic              step,
    input  logic [FRAC_W-1:0] frac,
    output fracn_pkg::mash_ofs_t ofs
);
    typedef struct packed {
        logic [FRAC_W-1:0] acc1;
        logic [FRAC_W-1:0] acc2;
        logic              c2_prev;
    } mash_st_t;

    mash_st_t st_d, st_q;
    logic [FRAC_W:0] sum1, sum2;

    always_comb begin
        sum1 = {1'b0, st_q.acc1} + {1'b0, frac};
        sum2 = {1'b0, st_q.acc2} + {1'b0, sum1[FRAC_W-1:0]};
        // first stage carry plus first difference of second stage carry
        ofs  = {2'b00, sum1[FRAC_W]} + {2'b00, sum2[FRAC_W]} - {2'b00, st_q.c2_prev};
        st_d = st_q;
        if (!active) begin
            st_d = '0;
        end else if (step) begin
            st_d.acc1    = sum1[FRAC_W-1:0];
            st_d.acc2    = sum2[FRAC_W-1:0];
            st_d.c2_prev = sum2[FRAC_W];
        end
    end

    always_ff @(posedge clk) begin
        if (srst) st_q <= '0;
        else      st_q <= st_d;
    end
endmodule

// File: rtl/fracn_ratio_mod.sv
module fracn_ratio_mod #(
    parameter int INT_W  = fracn_pkg::FRACN_INT_W,
    parameter int FRAC_W = fracn_pkg::FRACN_FRAC_W,
    parameter int RDIV_W = fracn_pkg::FRACN_RDIV_W,
    localparam int OUT_W = INT_W + 1
) (
    input  logic              clk,
    input  logic              srst,
    input  logic [RDIV_W-1:0] ref_div_val,
    input  logic [INT_W-1:0]  int_part,
    input  logic [FRAC_W-1:0] frac_word,
    input  logic              frac_mode,
    output logic              cmp_en,
    output logic [OUT_W-1:0]  div_val,
    output logic              range_err
);
    typedef struct packed {
        logic [OUT_W-1:0] div;
        logic             rerr;
    } top_st_t;

    top_st_t st_d, st_q;
    logic [INT_W-1:0] int_eff;
    logic             illegal;
    fracn_pkg::mash_ofs_t ofs;

    fracn_ref_div #(.RDIV_W(RDIV_W)) u_rdiv (
        .clk     (clk),
        .srst    (srst),
        .divisor (ref_div_val),
        .cmp_en  (cmp_en)
    );

    fracn_int_guard #(.INT_W(INT_W)) u_guard (
        .int_part  (int_part),
        .frac_mode (frac_mode),
        .int_eff   (int_eff),
        .illegal   (illegal)
    );

    fracn_mash11 #(.FRAC_W(FRAC_W)) u_mash (
        .clk    (clk),
        .srst   (srst),
        .active (frac_mode),
        .step   (cmp_en),
        .frac   (frac_word),
        .ofs    (ofs)
    );

    always_comb begin
        st_d      = st_q;
        st_d.rerr = illegal;
        if (cmp_en) begin
            if (frac_mode)
                st_d.div = {1'b0, int_eff} + {{(OUT_W-3){ofs[2]}}, ofs};
            else
                st_d.div = {1'b0, int_eff};
        end
    end

    always_ff @(posedge clk) begin
        if (srst) st_q <= '0;
        else      st_q <= st_d;
    end

    assign div_val   = st_q.div;
    assign range_err = st_q.rerr;
endmodule

// File: rtl/fracn_ratio_mod_chk.sv
module fracn_ratio_mod_chk #(
    parameter int INT_W  = fracn_pkg::FRACN_INT_W,
    parameter int RDIV_W = fracn_pkg::FRACN_RDIV_W,
    localparam int OUT_W = INT_W + 1
) (
    input logic              clk,
    input logic              srst,
    input logic [RDIV_W-1:0] ref_div_val,
    input logic [INT_W-1:0]  int_part,
    input logic              frac_mode,
    input logic              cmp_en,
    input logic [OUT_W-1:0]  div_val,
    input logic              range_err
);
    localparam logic [INT_W-1:0] MIN_V = INT_W'(fracn_pkg::FRACN_INT_MIN);
    localparam logic [INT_W-1:0] MAX_V = INT_W'(fracn_pkg::FRACN_FRAC_INT_MAX);
    localparam logic [OUT_W-1:0] CLAMP_LO = OUT_W'(fracn_pkg::FRACN_FRAC_INT_MAX - 1);
    localparam logic [OUT_W-1:0] CLAMP_HI = OUT_W'(fracn_pkg::FRACN_FRAC_INT_MAX + 2);

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (srst)
        (cmp_en && ref_div_val > RDIV_W'(1) && $stable(ref_div_val)) |=> !cmp_en);

    assert_always_on_R2: assert property (@(posedge clk) disable iff (srst)
        (ref_div_val <= RDIV_W'(1) && $stable(ref_div_val)) |=> cmp_en);

    assert_hold_R3: assert property (@(posedge clk) disable iff (srst)
        !cmp_en |=> $stable(div_val));

    assert_int_mode_R4: assert property (@(posedge clk) disable iff (srst)
        (cmp_en && !frac_mode && int_part >= MIN_V) |=> div_val == {1'b0, $past(int_part)});

    assert_frac_bounds_R5: assert property (@(posedge clk) disable iff (srst)
        (cmp_en && frac_mode && int_part >= MIN_V && int_part <= MAX_V) |=>
        (div_val + OUT_W'(1) >= {1'b0, $past(int_part)} &&
         div_val <= {1'b0, $past(int_part)} + OUT_W'(2)));

    assert_high_flag_R7: assert property (@(posedge clk) disable iff (srst)
        (frac_mode && int_part > MAX_V) |=> range_err);

    assert_high_clamp_R7: assert property (@(posedge clk) disable iff (srst)
        (cmp_en && frac_mode && int_part > MAX_V) |=>
        (div_val >= CLAMP_LO && div_val <= CLAMP_HI));

    assert_low_flag_R8: assert property (@(posedge clk) disable iff (srst)
        (int_part < MIN_V) |=> range_err);

    assert_legal_clear_R8: assert property (@(posedge clk) disable iff (srst)
        (int_part >= MIN_V && (!frac_mode || int_part <= MAX_V)) |=> !range_err);

    assert_reset_R1: assert property (@(posedge clk)
        srst |=> (div_val == '0 && !cmp_en && !range_err));
endmodule

bind fracn_ratio_mod fracn_ratio_mod_chk #(.INT_W(INT_W), .RDIV_W(RDIV_W)) u_chk (
    .clk         (clk),
    .srst        (srst),
    .ref_div_val (ref_div_val),
    .int_part    (int_part),
    .frac_mode   (frac_mode),
    .cmp_en      (cmp_en),
    .div_val     (div_val),
    .range_err   (range_err)
);

// File: tb/fracn_ratio_mod_bench.sv
`timescale 1ns/1ps
module fracn_ratio_mod_bench;
    logic        clk = 1'b0;
    logic        srst = 1'b1;
    logic [9:0]  ref_div_val = 10'd1;
    logic [14:0] int_part = 15'd100;
    logic [19:0] frac_word = '0;
    logic        frac_mode = 1'b0;
    logic        cmp_en;
    logic [15:0] div_val;
    logic        range_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fracn_ratio_mod u_fracn_ratio_mod (
        .clk(clk), .srst(srst), .ref_div_val(ref_div_val), .int_part(int_part),
        .frac_word(frac_word), .frac_mode(frac_mode), .cmp_en(cmp_en),
        .div_val(div_val), .range_err(range_err)
    );

    // Stimulus table: mode, integer part, fraction, divisor, updates, effective int, flag
    localparam int NV = 10;
    localparam int V_MODE[NV] = '{1, 1, 1, 1, 1, 0, 0, 1, 0, 1};
    localparam int V_INT [NV] = '{78, 100, 40, 200, 251, 1000, 32767, 300, 20, 10};
    localparam int V_FRAC[NV] = '{808452, 0, 1, 1048575, 524288, 12345, 777, 699051, 5, 262144};
    localparam int V_RDIV[NV] = '{1, 3, 1, 2, 1, 4, 1, 1, 2, 1};
    localparam int V_K   [NV] = '{65536, 2048, 4096, 4096, 4096, 1024, 1024, 4096, 512, 4096};
    localparam int V_IEFF[NV] = '{78, 100, 40, 200, 251, 1000, 32767, 251, 36, 36};
    localparam int V_ERR [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 1};

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_vec(input int i);
        longint sum = 0;
        longint lo, hi, diff;
        int     k = 0;
        bit     pend;
        bit     bad_rng = 0, bad_hold = 0;
        longint bad_val = 0, hold_val = 0;
        logic [15:0] last;
        // integer mode first so the modulator starts cleared (R6)
        @(negedge clk);
        frac_mode = 1'b0;
        repeat (8) @(negedge clk);
        frac_mode = V_MODE[i][0];
        int_part  = 15'(V_INT[i]);
        frac_word = 20'(V_FRAC[i]);
        ref_div_val = 10'(V_RDIV[i]);
        pend = cmp_en;
        last = div_val;
        while (k < V_K[i]) begin
            @(negedge clk);
            if (pend) begin
                sum += longint'(div_val);
                if (V_MODE[i] == 1) begin
                    if (int'(div_val) < V_IEFF[i] - 1 || int'(div_val) > V_IEFF[i] + 2) begin
                        bad_rng = 1; bad_val = div_val;
                    end
                end else if (int'(div_val) != V_IEFF[i]) begin
                    bad_rng = 1; bad_val = div_val;
                end
                k++;
            end else if (div_val != last) begin
                bad_hold = 1; hold_val = div_val;
            end
            last = div_val;
            pend = cmp_en;
        end
        if (V_MODE[i] == 1)
            check(!bad_rng, $sformatf("R5 vec%0d per-update range", i), bad_val, V_IEFF[i]);
        else
            check(!bad_rng, $sformatf("R4 vec%0d constant ratio", i), bad_val, V_IEFF[i]);
        check(!bad_hold, $sformatf("R3 vec%0d hold between updates", i), hold_val, last);
        lo = longint'(V_K[i]) * V_IEFF[i];
        hi = lo;
        if (V_MODE[i] == 1) begin
            lo += (longint'(V_K[i]) * V_FRAC[i]) >>> 20;
            hi = lo + 1;
        end
        check(sum >= lo && sum <= hi, $sformatf("R6 vec%0d update sum", i), sum, lo);
        if (i == 0) begin
            diff = sum * 1048576 - longint'(V_K[i]) * (longint'(V_IEFF[i]) * 1048576 + V_FRAC[i]);
            if (diff < 0) diff = -diff;
            check(diff < longint'(V_K[i]) * 256, "R6 mean within 2^-12", diff, 0);
        end
        if (V_ERR[i] == 1)
            check(range_err == 1'b1, $sformatf("R7/R8 vec%0d flag (R7 R8)", i), range_err, 1);
        else
            check(range_err == 1'b0, $sformatf("R8 vec%0d legal flag clear", i), range_err, 0);
    endtask

    task automatic period(input int n);
        int cyc = 0;
        int exp = (n == 0) ? 1 : n;
        @(negedge clk);
        frac_mode = 1'b0;
        ref_div_val = 10'(n);
        repeat (2) @(negedge clk);
        while (!cmp_en && cyc < 2100) begin @(negedge clk); cyc++; end
        cyc = 0;
        do begin @(negedge clk); cyc++; end while (!cmp_en && cyc < 2100);
        check(cyc == exp, $sformatf("R2 enable period N=%0d", n), cyc, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(div_val == 16'd0 && cmp_en == 1'b0 && range_err == 1'b0, "R1 reset state",
              div_val, 0);
        srst = 1'b0;
        for (int i = 0; i < NV; i++) run_vec(i);
        period(1);
        period(2);
        period(7);
        period(1023);
        period(0);
        // reset mid-run with an illegal setting active (R1)
        @(negedge clk);
        frac_mode = 1'b1; int_part = 15'd300; frac_word = 20'd9999; ref_div_val = 10'd1;
        repeat (6) @(negedge clk);
        srst = 1'b1;
        @(negedge clk);
        check(div_val == 16'd0 && range_err == 1'b0 && cmp_en == 1'b0, "R1 reset mid-run",
              {range_err, div_val}, 0);
        srst = 1'b0;
        @(negedge clk);
        check(range_err == 1'b1, "R7 flag after reset release", range_err, 1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule